// File: doc/BRIEF.md
# Double-Buffered Card Reader-Punch Controller

This block stands in for a combined card reader and card punch on a host I/O channel. A PC-side link writes an 80-column card image into a pre-read buffer, one 16-bit word per column. The host then starts a feed cycle with a read or a feed command. The controller steps through all columns in order. For each column it hands the word already held in the pre-punch buffer to the PC link as a finished card, and it copies the matching pre-read word into the pre-punch buffer.

Because of this double buffering, every feed cycle outputs the card that the previous cycle read. The first cycle after reset therefore outputs a blank card. A read raises a column interrupt for every column and passes the pre-read word to the host. A feed moves the data in the same way but raises no column interrupts. Both end with a single end-of-operation interrupt.

A status word reports not-ready, last-card and operation-complete, and a sense command returns it. After each cycle the hopper counts as empty, so the device stays not ready until the next image is loaded. While the device is not ready or busy, read, feed and stacker commands are dropped. A dropped command is never kept to run later.

Top module: `cardRdrPunch`

## Requirements
- R1: After reset, `fetchValid`, `irqCol` and `irqEnd` are low and `loadReady` is high. A sense command returns status 0x0001, which means not ready.
- R2: A load beat is accepted when `loadValid` and `loadReady` are both high, and it writes `loadData` into column `loadCol` (0 to 79) of the pre-read buffer. An accepted beat to column 79 completes the image and clears not-ready. `loadReady` is low for the whole of a feed cycle.
- R3: A feed cycle delivers exactly 80 words on the fetch port, for columns 0 to 79 in ascending order, one per handshake (`fetchValid` and `fetchReady` both high). The first cycle after reset delivers 80 zero words.
- R4: Every feed cycle copies every column of the pre-read buffer into the pre-punch buffer. The next feed cycle therefore delivers exactly the image that was loaded before the current one.
- R5: In a read cycle (`cmdOp`=1), `irqCol` pulses on each column handshake, with `colData` equal to that column's pre-read word. A feed cycle (`cmdOp`=2) raises no `irqCol`.
- R6: Each read or feed cycle ends with exactly one single-cycle `irqEnd` pulse, and sets operation-complete (status bit value 0x0004).
- R7: Read, feed and stacker commands (`cmdOp`=1, 2, 3) are ignored while the device is not ready or a feed cycle is running. An ignored command never starts a cycle, including after a later load makes the device ready.
- R8: A sense command (`cmdOp`=0) is accepted in any state. In the next cycle `dswValid` pulses, and `dswData` holds the status word with not-ready at 0x0001, last-card at 0x0002 and operation-complete at 0x0004.
- R9: If `loadLastCard` is high on the column-79 beat of an image, last-card (0x0002) is set at the end of the feed cycle that reads that image. A cycle that reads an image loaded without the flag leaves last-card clear.
- R10: At the end of every feed cycle the device becomes not ready (0x0001), and stays so until the next image is complete.
- R11: A stacker command (`cmdOp`=3) makes `fetchAlt` high for all 80 words of the next feed cycle. `fetchAlt` is low in the cycle after that unless another stacker command is given.
- R12: A sense with `cmdClear` high returns the status as it stood before the command, then clears last-card and operation-complete. It leaves not-ready unchanged.
- R13: While `fetchValid` is high and `fetchReady` is low, `fetchData` and `fetchCol` hold steady and the column does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Host command strobe |
| cmdOp | input | 2 | Command: 0 sense, 1 read, 2 feed, 3 alternate stacker |
| cmdClear | input | 1 | With sense: clear last-card and operation-complete after reporting |
| dswValid | output | 1 | Status word valid, one cycle after a sense |
| dswData | output | 16 | Status word |
| irqCol | output | 1 | Per-column interrupt request, read cycles only |
| colData | output | 16 | Pre-read word of the current column |
| irqEnd | output | 1 | End-of-operation interrupt request |
| loadValid | input | 1 | PC link load beat valid |
| loadReady | output | 1 | Pre-read buffer may be written |
| loadCol | input | 7 | Column of the load beat |
| loadData | input | 16 | Column word to load |
| loadLastCard | input | 1 | Image is the last card, sampled on the column-79 beat |
| fetchValid | output | 1 | Finished-card word valid |
| fetchReady | input | 1 | PC link accepts the word |
| fetchCol | output | 7 | Column of the fetch word, also the interrupting column |
| fetchData | output | 16 | Finished-card word |
| fetchAlt | output | 1 | Finished card goes to the alternate stacker |

## Verification
Three card images with different base values pass through in sequence, using read, feed, read. This separates a blank first card, a one-card delay and a broken or partial copy: each position's word is distinct, so a zeroed or stale column shows up. One cycle runs under a periodic `fetchReady` stall, which would expose a column that advances without a handshake. Commands are given while the device is not ready, while it is busy, and just before a load. These separate a command that is dropped from one that is queued and resumes on load. Sense commands with and without the clear bit, with the last-card flag set on one image only, separate the latched status bits from each other.

// File: rtl/cardPkg.sv
package cardPkg;

  typedef enum logic [1:0] {
    OP_SENSE = 2'd0,
    OP_READ  = 2'd1,
    OP_FEED  = 2'd2,
    OP_STACK = 2'd3
  } cmdOpE;

  // Strobes from the control FSM to the buffer datapath.
  typedef struct packed {
    logic copyWr;
    logic loadWr;
  } dpStrobeT;

  localparam int ST_NOT_READY = 0;
  localparam int ST_LAST_CARD = 1;
  localparam int ST_OP_DONE   = 2;

endpackage

// File: rtl/cardBuffers.sv
module cardBuffers
  import cardPkg::*;
#(
  parameter int COLS  = 80,
  parameter int W     = 16,
  parameter int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobeT         strobes,
  input  logic [COL_W-1:0] col,
  input  logic [COL_W-1:0] loadCol,
  input  logic [W-1:0]     loadData,
  output logic [W-1:0]     preWord,
  output logic [W-1:0]     punchWord
);

  logic [W-1:0] preRead  [COLS];
  logic [W-1:0] prePunch [COLS];

  always_ff @(posedge clk) begin
    if (strobes.loadWr) preRead[loadCol] <= loadData;
  end

  // The pre-punch buffer starts blank, so the first card out is empty.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < COLS; i++) prePunch[i] <= '0;
    end else if (strobes.copyWr) begin
      prePunch[col] <= preRead[col];
    end
  end

  assign preWord   = preRead[col];
  assign punchWord = prePunch[col];

endmodule

// File: rtl/cardFeedCtl.sv
module cardFeedCtl
  import cardPkg::*;
#(
  parameter int COLS  = 80,
  parameter int W     = 16,
  parameter int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic             cmdClear,
  output logic             dswValid,
  output logic [W-1:0]     dswData,
  output logic             irqCol,
  output logic             irqEnd,
  input  logic             loadValid,
  output logic             loadReady,
  input  logic [COL_W-1:0] loadCol,
  input  logic             loadLastCard,
  output logic             fetchValid,
  input  logic             fetchReady,
  output logic             fetchAlt,
  output logic [COL_W-1:0] col,
  output dpStrobeT         strobes
);

  typedef enum logic [1:0] {S_IDLE, S_COPY, S_DONE} stateE;

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  stateE        state;
  logic         readMode, notReady, lastPend, lastBit, opDone, altSel;
  logic         loadFire, lastBeat, handshake, accept, startOk, stackOk, senseCmd;
  cmdOpE        op;
  logic [W-1:0] statusWord;

  assign op        = cmdOpE'(cmdOp);
  assign loadReady = (state == S_IDLE);
  assign loadFire  = loadValid && loadReady && ({1'b0, loadCol} < (COL_W + 1)'(COLS));
  assign lastBeat  = loadFire && (loadCol == LAST_COL);
  assign fetchValid = (state == S_COPY);
  assign handshake = fetchValid && fetchReady;
  assign accept    = cmdValid && (state == S_IDLE) && !notReady;
  assign startOk   = accept && (op == OP_READ || op == OP_FEED);
  assign stackOk   = accept && (op == OP_STACK);
  assign senseCmd  = cmdValid && (op == OP_SENSE);

  assign irqCol   = handshake && readMode;
  assign irqEnd   = (state == S_DONE);
  assign fetchAlt = altSel;

  assign strobes.copyWr = handshake;
  assign strobes.loadWr = loadFire;

  always_comb begin
    statusWord = '0;
    statusWord[ST_NOT_READY] = notReady;
    statusWord[ST_LAST_CARD] = lastBit;
    statusWord[ST_OP_DONE]   = opDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      col      <= '0;
      readMode <= 1'b0;
      notReady <= 1'b1;
      lastPend <= 1'b0;
      lastBit  <= 1'b0;
      opDone   <= 1'b0;
      altSel   <= 1'b0;
      dswValid <= 1'b0;
      dswData  <= '0;
    end else begin
      dswValid <= senseCmd;
      if (senseCmd) begin
        dswData <= statusWord;
        if (cmdClear) begin
          opDone  <= 1'b0;
          lastBit <= 1'b0;
        end
      end
      if (lastBeat) begin
        notReady <= 1'b0;
        lastPend <= loadLastCard;
      end
      case (state)
        S_IDLE: begin
          if (startOk) begin
            state    <= S_COPY;
            col      <= '0;
            readMode <= (op == OP_READ);
          end
          if (stackOk) altSel <= 1'b1;
        end
        S_COPY: begin
          if (handshake) begin
            if (col == LAST_COL) state <= S_DONE;
            else col <= col + 1'b1;
          end
        end
        S_DONE: begin
          opDone   <= 1'b1;
          lastBit  <= lastPend;
          lastPend <= 1'b0;
          notReady <= 1'b1;
          altSel   <= 1'b0;
          col      <= '0;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cardRdrPunch.sv
module cardRdrPunch
  import cardPkg::*;
#(
  parameter int COLS  = 80,
  parameter int W     = 16,
  parameter int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic             cmdClear,
  output logic             dswValid,
  output logic [W-1:0]     dswData,
  output logic             irqCol,
  output logic [W-1:0]     colData,
  output logic             irqEnd,
  input  logic             loadValid,
  output logic             loadReady,
  input  logic [COL_W-1:0] loadCol,
  input  logic [W-1:0]     loadData,
  input  logic             loadLastCard,
  output logic             fetchValid,
  input  logic             fetchReady,
  output logic [COL_W-1:0] fetchCol,
  output logic [W-1:0]     fetchData,
  output logic             fetchAlt
);

  dpStrobeT         strobes;
  logic [COL_W-1:0] col;

  cardFeedCtl #(.COLS(COLS), .W(W), .COL_W(COL_W)) ctl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdClear(cmdClear),
    .dswValid(dswValid), .dswData(dswData),
    .irqCol(irqCol), .irqEnd(irqEnd),
    .loadValid(loadValid), .loadReady(loadReady), .loadCol(loadCol),
    .loadLastCard(loadLastCard),
    .fetchValid(fetchValid), .fetchReady(fetchReady), .fetchAlt(fetchAlt),
    .col(col), .strobes(strobes)
  );

  cardBuffers #(.COLS(COLS), .W(W), .COL_W(COL_W)) bufs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .col(col),
    .loadCol(loadCol), .loadData(loadData),
    .preWord(colData), .punchWord(fetchData)
  );

  assign fetchCol = col;

endmodule

// File: rtl/cardRdrPunchChk.sv
module cardRdrPunchChk #(
  parameter int COLS  = 80,
  parameter int W     = 16,
  parameter int COL_W = $clog2(COLS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [1:0]       cmdOp,
  input logic             dswValid,
  input logic             irqCol,
  input logic             irqEnd,
  input logic             loadReady,
  input logic             fetchValid,
  input logic             fetchReady,
  input logic [COL_W-1:0] fetchCol,
  input logic [W-1:0]     fetchData
);

  // R5: a column interrupt only accompanies a column handshake
  a_r5_irq_on_handshake: assert property (@(posedge clk) disable iff (!rstN)
    irqCol |-> (fetchValid && fetchReady));

  // R6: the end pulse lasts one cycle and the cycle is over after it
  a_r6_single_end: assert property (@(posedge clk) disable iff (!rstN)
    irqEnd |=> (!irqEnd && !fetchValid && loadReady));

  // R6: never both interrupt kinds together
  a_r6_irq_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqCol, irqEnd}));

  // R2: no loading into the pre-read buffer during a copy
  a_r2_no_load_busy: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> !loadReady);

  // R3: columns advance by one per handshake
  a_r3_col_order: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchReady && fetchCol != COL_W'(COLS - 1)) |=>
      (fetchValid && fetchCol == COL_W'($past(fetchCol) + 1'b1)));

  // R13: a stalled word holds still
  a_r13_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !fetchReady) |=>
      (fetchValid && $stable(fetchData) && $stable(fetchCol)));

  // R8: status replies only follow a sense command
  a_r8_sense_reply: assert property (@(posedge clk) disable iff (!rstN)
    dswValid |-> $past(cmdValid && cmdOp == 2'd0));

endmodule

bind cardRdrPunch cardRdrPunchChk #(.COLS(COLS), .W(W), .COL_W(COL_W)) chk (.*);

// File: tb/cardRdrPunch_test.sv
module cardRdrPunch_test;
  localparam int COLS = 80;
  localparam int W = 16;
  localparam int COL_W = $clog2(COLS);

  logic clk = 0, rstN = 0;
  logic cmdValid = 0, cmdClear = 0;
  logic [1:0] cmdOp = 0;
  logic dswValid, irqCol, irqEnd, loadReady, fetchValid, fetchAlt;
  logic [W-1:0] dswData, colData, fetchData;
  logic loadValid = 0, loadLastCard = 0, fetchReady = 1;
  logic [COL_W-1:0] loadCol = 0, fetchCol;
  logic [W-1:0] loadData = 0;

  cardRdrPunch uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdClear(cmdClear),
    .dswValid(dswValid), .dswData(dswData), .irqCol(irqCol), .colData(colData),
    .irqEnd(irqEnd), .loadValid(loadValid), .loadReady(loadReady), .loadCol(loadCol),
    .loadData(loadData), .loadLastCard(loadLastCard), .fetchValid(fetchValid),
    .fetchReady(fetchReady), .fetchCol(fetchCol), .fetchData(fetchData), .fetchAlt(fetchAlt)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int irqColCnt = 0, irqEndCnt = 0, tick = 0;
  bit stallMode = 0, expAlt = 0, done = 0;
  logic [W-1:0] expFetch[$];
  logic [W-1:0] expCol[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected items as the design delivers them
  always @(negedge clk) begin
    tick++;
    if (rstN && fetchValid && fetchReady) begin
      if (expFetch.size() == 0) check(0, "R3 extra fetch word", fetchData, 0);
      else begin
        logic [W-1:0] e;
        e = expFetch.pop_front();
        check(fetchData == e, "R4 fetch word", fetchData, e);
        check(fetchAlt == expAlt, "R11 stacker select", fetchAlt, expAlt);
      end
    end
    if (rstN && irqCol) begin
      irqColCnt++;
      if (expCol.size() == 0) check(0, "R5 unexpected column irq", colData, 0);
      else begin
        logic [W-1:0] e;
        e = expCol.pop_front();
        check(colData == e, "R5 column data", colData, e);
      end
    end
    if (rstN && irqEnd) irqEndCnt++;
    fetchReady = stallMode ? ((tick % 3) != 0) : 1'b1;
  end

  task automatic issue(input logic [1:0] op, input bit clr);
    @(negedge clk);
    cmdValid = 1; cmdOp = op; cmdClear = clr;
    @(negedge clk);
    cmdValid = 0; cmdClear = 0;
  endtask

  task automatic sense(input bit clr, input logic [W-1:0] exp, input string req);
    issue(2'd0, clr);
    check(dswValid && dswData == exp, req, {dswValid, dswData}, {1'b1, exp});
  endtask

  task automatic loadCard(input logic [W-1:0] base, input bit last);
    for (int c = 0; c < COLS; c++) begin
      @(negedge clk);
      loadValid = 1; loadCol = COL_W'(c); loadData = base + W'(c); loadLastCard = last;
    end
    @(negedge clk);
    loadValid = 0; loadLastCard = 0;
  endtask

  task automatic expectCard(input logic [W-1:0] base, input bit blank);
    for (int c = 0; c < COLS; c++) expFetch.push_back(blank ? '0 : base + W'(c));
  endtask

  task automatic expectCols(input logic [W-1:0] base);
    for (int c = 0; c < COLS; c++) expCol.push_back(base + W'(c));
  endtask

  task automatic waitEnd(input int target);
    int guard = 0;
    while (irqEndCnt < target && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(irqEndCnt == target, "R6 end interrupt", irqEndCnt, target);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!fetchValid && !irqCol && !irqEnd && loadReady, "R1 reset outputs",
          {fetchValid, irqCol, irqEnd, loadReady}, 4'b0001);
    sense(0, 16'h0001, "R1 reset status");

    // R7: command while not ready is dropped
    issue(2'd1, 0);
    repeat (5) @(negedge clk);
    check(!fetchValid && irqEndCnt == 0, "R7 read while not ready", fetchValid, 0);

    loadCard(16'hA000, 0);
    sense(0, 16'h0000, "R2 load clears not-ready");

    // First read: blank card out, card A per-column to host
    expAlt = 0;
    expectCard(16'h0, 1);
    expectCols(16'hA000);
    issue(2'd1, 0);
    check(fetchValid && !loadReady, "R2 load blocked while busy", {fetchValid, loadReady}, 2'b10);
    issue(2'd2, 0); // R7: feed while busy
    waitEnd(1);
    check(expFetch.size() == 0, "R3 blank card fully delivered", expFetch.size(), 0);
    check(irqColCnt == COLS, "R5 read column irqs", irqColCnt, COLS);
    check(!fetchValid && irqEndCnt == 1, "R7 busy command dropped", irqEndCnt, 1);
    sense(0, 16'h0005, "R10 not ready after cycle, R6 op complete");

    // R7: not kept pending across a load
    issue(2'd2, 0);
    repeat (5) @(negedge clk);
    loadCard(16'hB100, 1);
    repeat (5) @(negedge clk);
    check(!fetchValid && irqEndCnt == 1, "R7 no pending start after load", irqEndCnt, 1);

    sense(1, 16'h0004, "R12 clear returns prior status");
    sense(0, 16'h0000, "R12 bits cleared");

    // Alternate stacker, feed with stalls: card A comes out
    issue(2'd3, 0);
    expAlt = 1;
    expectCard(16'hA000, 0);
    stallMode = 1;
    issue(2'd2, 0);
    waitEnd(2);
    stallMode = 0;
    check(expFetch.size() == 0, "R13 all words under stall", expFetch.size(), 0);
    check(irqColCnt == COLS, "R5 feed raises no column irq", irqColCnt, COLS);
    sense(0, 16'h0007, "R9 last card set");
    sense(1, 16'h0007, "R12 clear with last card");
    sense(0, 16'h0001, "R12 not-ready kept");

    // Third cycle: card B comes out on normal stacker
    loadCard(16'hC200, 0);
    expAlt = 0;
    expectCard(16'hB100, 0);
    expectCols(16'hC200);
    issue(2'd1, 0);
    waitEnd(3);
    check(expFetch.size() == 0 && expCol.size() == 0, "R4 previous card delivered",
          expFetch.size(), 0);
    check(irqColCnt == 2 * COLS, "R5 second read irqs", irqColCnt, 2 * COLS);
    sense(0, 16'h0005, "R9 last card clear for unflagged image");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule